// File: doc/BRIEF.md
# Multi-Tau Photon Autocorrelator

This block forms an intensity autocorrelation in real time from a stream of photon counts, one count per system cycle, over a lag range that grows geometrically along a cascade of stages. The raw sample stream is never stored. Stage 0 takes every count as it arrives. Each later stage sees a sample that is the sum of two consecutive samples of the stage before it, so its sample period is twice as long. Every stage keeps a short delay line of its own past samples. On each of its sample slots, every channel multiplies the current sample by one delayed sample and adds the product into a 64-bit accumulator. Each stage also keeps a 64-bit sum of its own samples, which is used later for symmetric normalization.

A per-stage cycle counter produces the sample slots as clock enables. Stage s counts from 1 up to 2^s and fires in the cycle where the count equals 2^s, so all stages share one clock. A small control machine has three states. IDLE is entered on reset and on clear. RUN accumulates. HOLD freezes everything. The transitions are: start-in-IDLE, which goes to RUN; stop-in-RUN, which goes to HOLD; start-in-HOLD, which goes back to RUN; and clear-from-any-state, which goes to IDLE. Results are read by stage and channel through a registered read port that has one cycle of latency.

Top module: `mtau_corr`

## Requirements
- R1: Stage 0 has 16 channels and every later stage has 8. Channel k of stage s (k counted from 0) accumulates, modulo 2^64, the product of the stage's current sample and its sample from k+1 sample periods earlier. Delay slots that have not yet been filled count as zero.
- R2: The stage 0 sample is the input count of a RUN cycle. The stage s sample is the sum of the inputs of the 2^s consecutive RUN cycles that end in the RUN cycle whose 1-based index is a multiple of 2^s. This sum is formed by adding pairs of stage s-1 samples.
- R3: The enable of stage s comes from a counter that runs from 1 to 2^s. The enable is high only in the RUN cycle where the counter equals 2^s, after which the counter wraps to 1. As a result, an enable of stage s implies an enable of stage s-1.
- R4: Clear takes priority over all other inputs. It zeroes every accumulator, monitor sum, delay line and enable counter, and it puts the control machine in IDLE. Reset does the same.
- R5: Outside RUN, no enable fires and no accumulator, monitor sum or counter changes, whatever the input count is.
- R6: The control transitions are: start in IDLE or in HOLD leads to RUN; stop in RUN leads to HOLD; stop in IDLE is ignored. When start and stop arrive together outside RUN, the machine goes to RUN.
- R7: Each stage keeps a monitor sum, equal to the sum of all its samples since the last clear.
- R8: The read port registers the accumulator and the monitor sum selected by (rd_stage, rd_chan) and shows them in the cycle after the address is applied. A channel index at or beyond the stage's channel count reads as zero. A stage index at or beyond the stage count reads as zero on both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of all results; returns to IDLE |
| start | input | 1 | Begin or resume accumulation |
| stop | input | 1 | Freeze accumulation |
| cnt_in | input | CNT_W | Photon count for the current cycle |
| rd_stage | input | STG_W | Stage index to read |
| rd_chan | input | 4 | Channel index to read |
| rd_acc | output | 64 | Selected channel accumulator, one cycle after the address |
| rd_mon | output | 64 | Monitor sum of the selected stage, one cycle after the address |

## Verification
A small configuration with three stages is run with four count patterns, and after each one every channel and every monitor sum is compared with products computed in the bench from the recorded RUN-cycle inputs. A constant stream makes all lags equal, which exposes a miscounted channel or a wrong pair window. A ramp of odd length that is split by a stop and a resume shows whether a half-formed pair survives HOLD. Sparse large pulses put weight on single lags and on the stage-boundary sums. Separate runs check the following: input ignored in HOLD and in IDLE, a clear that arrives during RUN, start and stop in the same cycle, and out-of-range read addresses.

// File: rtl/mtau_pkg.sv
package mtau_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_t;

    localparam int FIRST_CH = 16;
    localparam int LATER_CH = 8;
    localparam int ACC_W    = 64;
    localparam int CH_W     = $clog2(FIRST_CH);

    function automatic int stage_ch(input int s);
        return (s == 0) ? FIRST_CH : LATER_CH;
    endfunction

endpackage

// File: rtl/mtau_ctrl.sv
module mtau_ctrl
    import mtau_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    input  logic stop,
    output logic run_o
);

    run_state_t state_q;
    run_state_t state_d;

    // State register (R4: reset lands in IDLE)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions (R4 clear priority, R6 start/stop rules)
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) state_d = ST_RUN;
                ST_RUN:  if (stop)  state_d = ST_HOLD;
                ST_HOLD: if (start) state_d = ST_RUN;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        run_o = (state_q == ST_RUN);
    end

endmodule

// File: rtl/mtau_tick.sv
module mtau_tick #(
    parameter int STAGE = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run_i,
    output logic en_o
);

    generate
        if (STAGE == 0) begin : g_every
            assign en_o = run_i;
        end else begin : g_div
            localparam int CW = STAGE + 1;
            localparam logic [CW-1:0] DIV = {1'b1, {STAGE{1'b0}}};
            logic [CW-1:0] cnt_q;

            // R3: count 1..2^s over RUN cycles, wrap after the top value
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= CW'(1);
                end else if (clr) begin
                    cnt_q <= CW'(1);
                end else if (run_i) begin
                    cnt_q <= (cnt_q == DIV) ? CW'(1) : cnt_q + CW'(1);
                end
            end

            assign en_o = run_i && (cnt_q == DIV);
        end
    endgenerate

endmodule

// File: rtl/mtau_stage.sv
module mtau_stage #(
    parameter int CH     = 8,
    parameter int SAMP_W = 8,
    parameter int ACC_W  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       en_i,
    input  logic [SAMP_W-1:0]          samp_i,
    output logic [CH-1:0][ACC_W-1:0]   acc_o,
    output logic [ACC_W-1:0]           mon_o
);

    logic [CH-1:0][SAMP_W-1:0] dly_q;
    logic [CH-1:0][ACC_W-1:0]  prod;
    logic [CH-1:0][ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]          mon_q;

    // R1: one product per channel, lag k+1 sample periods
    always_comb begin
        for (int k = 0; k < CH; k++) begin
            prod[k] = ACC_W'(samp_i) * ACC_W'(dly_q[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
            acc_q <= '0;
            mon_q <= '0;
        end else if (clr) begin
            dly_q <= '0;
            acc_q <= '0;
            mon_q <= '0;
        end else if (en_i) begin
            for (int k = 0; k < CH; k++) begin
                acc_q[k] <= acc_q[k] + prod[k];
            end
            dly_q <= {dly_q[CH-2:0], samp_i};
            mon_q <= mon_q + ACC_W'(samp_i);  // R7
        end
    end

    assign acc_o = acc_q;
    assign mon_o = mon_q;

endmodule

// File: rtl/mtau_corr.sv
module mtau_corr
    import mtau_pkg::*;
#(
    parameter int NUM_STAGES = 35,
    parameter int CNT_W      = 4,
    localparam int STG_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start,
    input  logic              stop,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [STG_W-1:0]  rd_stage,
    input  logic [CH_W-1:0]   rd_chan,
    output logic [ACC_W-1:0]  rd_acc,
    output logic [ACC_W-1:0]  rd_mon
);

    localparam int SAMP_W = CNT_W + NUM_STAGES;

    logic                  run;
    logic [NUM_STAGES-1:0] stage_en;
    logic [ACC_W-1:0]      acc_tab [NUM_STAGES][FIRST_CH];
    logic [ACC_W-1:0]      mon_tab [NUM_STAGES];
    logic [ACC_W-1:0]      acc_sel;
    logic [ACC_W-1:0]      mon_sel;

    mtau_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .start (start),
        .stop  (stop),
        .run_o (run)
    );

    generate
        for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
            localparam int CH = stage_ch(s);
            logic [SAMP_W-1:0]        samp_w;
            logic [CH-1:0][ACC_W-1:0] acc_w;
            logic [ACC_W-1:0]         mon_w;

            mtau_tick #(.STAGE(s)) u_tick (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .run_i (run),
                .en_o  (stage_en[s])
            );

            if (s == 0) begin : g_src
                assign samp_w = SAMP_W'(cnt_in);
            end else begin : g_pair
                // R2: hold the first of a pair, add the second when this stage fires
                logic [SAMP_W-1:0] half_q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        half_q <= '0;
                    end else if (stage_en[s-1] && !stage_en[s]) begin
                        half_q <= g_stage[s-1].samp_w;
                    end
                end
                assign samp_w = half_q + g_stage[s-1].samp_w;
            end

            mtau_stage #(
                .CH     (CH),
                .SAMP_W (SAMP_W),
                .ACC_W  (ACC_W)
            ) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (clr),
                .en_i   (stage_en[s]),
                .samp_i (samp_w),
                .acc_o  (acc_w),
                .mon_o  (mon_w)
            );

            for (genvar c = 0; c < FIRST_CH; c++) begin : g_tab
                if (c < CH) begin : g_real
                    assign acc_tab[s][c] = acc_w[c];
                end else begin : g_pad
                    assign acc_tab[s][c] = '0;  // R8: absent channel reads zero
                end
            end
            assign mon_tab[s] = mon_w;
        end
    endgenerate

    // R8: address decode, out-of-range stage yields zero
    always_comb begin
        acc_sel = '0;
        mon_sel = '0;
        for (int s = 0; s < NUM_STAGES; s++) begin
            if (rd_stage == STG_W'(s)) begin
                acc_sel = acc_tab[s][rd_chan];
                mon_sel = mon_tab[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_acc <= '0;
            rd_mon <= '0;
        end else begin
            rd_acc <= acc_sel;
            rd_mon <= mon_sel;
        end
    end

endmodule

// File: rtl/mtau_corr_chk.sv
module mtau_corr_chk #(
    parameter int NS    = 3,
    parameter int STG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             start,
    input logic             stop,
    input logic             run,
    input logic [NS-1:0]    stage_en,
    input logic [STG_W-1:0] rd_stage,
    input logic [63:0]      rd_acc,
    input logic [63:0]      rd_mon
);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (stage_en == '0));

    assert_clear_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !run);

    assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && stop && !clr) |=> !run);

    assert_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && start && !clr) |=> run);

    assert_rd_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_stage) >= NS) |=> (rd_acc == '0 && rd_mon == '0));

    generate
        if (NS > 1) begin : g_multi
            assert_en1_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
                stage_en[1] |=> !stage_en[1]);
            for (genvar s = 1; s < NS; s++) begin : g_nest
                assert_en_nested_R3: assert property (@(posedge clk) disable iff (!rst_n)
                    stage_en[s] |-> stage_en[s-1]);
            end
        end
    endgenerate

endmodule

bind mtau_corr mtau_corr_chk #(
    .NS    (NUM_STAGES),
    .STG_W (STG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .start    (start),
    .stop     (stop),
    .run      (run),
    .stage_en (stage_en),
    .rd_stage (rd_stage),
    .rd_acc   (rd_acc),
    .rd_mon   (rd_mon)
);

// File: tb/mtau_corr_tb.sv
module mtau_corr_tb;

    localparam int NS  = 3;
    localparam int CW  = 4;
    localparam int STW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic [CW-1:0] cnt_in = '0;
    logic [STW-1:0] rd_stage = '0;
    logic [3:0]    rd_chan = '0;
    logic [63:0]   rd_acc;
    logic [63:0]   rd_mon;

    always #4 clk = ~clk;

    mtau_corr #(.NUM_STAGES(NS), .CNT_W(CW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .start    (start),
        .stop     (stop),
        .cnt_in   (cnt_in),
        .rd_stage (rd_stage),
        .rd_chan  (rd_chan),
        .rd_acc   (rd_acc),
        .rd_mon   (rd_mon)
    );

    int total = 0;
    int bad   = 0;
    int xs[$];
    bit model_run = 1'b0;

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ch_of(input int s);
        return (s == 0) ? 16 : 8;
    endfunction

    function automatic longint unsigned samp_of(input int s, input int m);
        longint unsigned t;
        int l;
        l = 1 << s;
        t = 0;
        for (int j = 0; j < l; j++) t += longint'(xs[m*l + j]);
        return t;
    endfunction

    function automatic longint unsigned exp_acc(input int s, input int k);
        longint unsigned r;
        int m_cnt;
        m_cnt = xs.size() / (1 << s);
        r = 0;
        for (int m = k + 1; m < m_cnt; m++) r += samp_of(s, m) * samp_of(s, m - k - 1);
        return r;
    endfunction

    function automatic longint unsigned exp_mon(input int s);
        longint unsigned r;
        int m_cnt;
        m_cnt = xs.size() / (1 << s);
        r = 0;
        for (int m = 0; m < m_cnt; m++) r += samp_of(s, m);
        return r;
    endfunction

    task automatic tick_in(input int x);
        @(negedge clk);
        cnt_in = CW'(x);
        @(posedge clk);
        if (model_run) xs.push_back(x);
        #1;
        cnt_in = '0;
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        model_run = 1'b1;
        #1;
        start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        stop = 1'b1;
        @(posedge clk);
        if (model_run) xs.push_back(0);
        model_run = 1'b0;
        #1;
        stop = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(posedge clk);
        xs.delete();
        model_run = 1'b0;
        #1;
        clr = 1'b0;
    endtask

    task automatic rd(input int s, input int c, output longint unsigned a, output longint unsigned mo);
        @(negedge clk);
        rd_stage = STW'(s);
        rd_chan  = 4'(c);
        @(negedge clk);
        a  = rd_acc;
        mo = rd_mon;
    endtask

    task automatic verify_all(input string tag);
        longint unsigned a;
        longint unsigned mo;
        for (int s = 0; s < NS; s++) begin
            for (int c = 0; c < 16; c++) begin
                rd(s, c, a, mo);
                chk($sformatf("%s R1 R8 stage%0d ch%0d", tag, s, c), a,
                    (c < ch_of(s)) ? exp_acc(s, c) : 64'd0);
                if (c == 0) chk($sformatf("%s R7 mon stage%0d", tag, s), mo, exp_mon(s));
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL R6 watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint unsigned a;
        longint unsigned mo;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R4: reset state reads all zero
        verify_all("R4 reset");

        // R1 R2 R7: constant stream
        do_start();
        for (int i = 0; i < 32; i++) tick_in(1);
        do_stop();
        verify_all("R2 constant");

        // R5: input during HOLD changes nothing
        for (int i = 0; i < 10; i++) tick_in(9);
        verify_all("R5 hold");

        // R2 R3: odd-length ramp resumed across a stop; partial pair carried
        do_start();
        for (int i = 0; i < 37; i++) tick_in(i % 16);
        do_stop();
        verify_all("R3 ramp resume");

        // R4: clear empties everything
        do_clear();
        verify_all("R4 clear");

        // R6: stop in IDLE is ignored, input in IDLE does nothing
        do_stop();
        for (int i = 0; i < 5; i++) tick_in(5);
        verify_all("R6 idle stop");

        // R1 R2: sparse large pulses
        do_start();
        for (int i = 0; i < 48; i++) tick_in((i % 7 == 0) ? 15 : 0);
        do_stop();
        verify_all("R1 sparse");

        // R4: clear during RUN wins and leaves IDLE
        do_clear();
        do_start();
        for (int i = 0; i < 20; i++) tick_in(15);
        do_clear();
        for (int i = 0; i < 6; i++) tick_in(3);
        verify_all("R4 clear in run");

        // R6: start and stop together outside RUN go to RUN
        @(negedge clk);
        start = 1'b1;
        stop  = 1'b1;
        @(posedge clk);
        model_run = 1'b1;
        #1;
        start = 1'b0;
        stop  = 1'b0;
        for (int i = 0; i < 24; i++) tick_in(15 - (i % 4));
        do_stop();
        verify_all("R6 start+stop");

        // R8: stage index beyond the stage count reads zero
        rd(3, 0, a, mo);
        chk("R8 bad stage acc", a, 64'd0);
        chk("R8 bad stage mon", mo, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule